// File: doc/BRIEF.md
# Indexed Block-Access Configuration Slave (two-wire serial bus)

This block is a serial-bus slave that holds a small file of byte-wide configuration registers and makes every byte available as a parallel output. The bus lines are oversampled by the much faster system clock. Each line passes through a two-stage synchroniser, and edge logic then derives SCL rising and falling events plus start and stop conditions. The slave pulls SDA low through an open-drain enable for its acknowledge bits and for zero-valued read bits.

A host writes by sending the write address, a starting register index and a byte count, followed by the data bytes. To read, the host first sets the index with a short write phase and then issues a repeated start with the read address. The slave answers with the content of the count register (index 8), followed by the registers from the index onwards. The index pointer wraps around the register file. Data travels MSB first.

The controller is one state machine with these states:
- ST_IDLE
- ST_ADDR (address shift)
- ST_ADDR_ACK
- ST_INDEX
- ST_INDEX_ACK
- ST_COUNT
- ST_COUNT_ACK
- ST_WDATA
- ST_WDATA_ACK
- ST_RDATA (slave transmits)
- ST_RACK (host acknowledge slot)
- ST_WAIT (ignore traffic)

Transitions happen on SCL falling events:
- ADDR goes to ADDR_ACK when the address matches, and to WAIT when it does not.
- ADDR_ACK goes to INDEX for a write and to RDATA for a read.
- INDEX goes to INDEX_ACK, then to COUNT.
- COUNT goes to COUNT_ACK, then to WDATA.
- WDATA goes to WDATA_ACK while the count has bytes left, and back to WDATA after the slot. With no bytes left it goes to WAIT.
- RDATA goes to RACK. RACK goes back to RDATA on a host ACK and to WAIT on a NACK.

Two events override every state: a start in any state enters ADDR, and a stop in any state enters IDLE.

Top module: `smb_idx_slave`

## Requirements
- R1: An address byte of 0xDC (write) or 0xDD (read) is acknowledged by SDA held low in the ninth clock. Any other address is not acknowledged, and every following byte is neither acknowledged nor stored until the next start.
- R2: A start (SDA falls while SCL is high) seen in any state, including partway through a byte, restarts the address phase. A stop (SDA rises while SCL is high) returns the slave to idle with SDA released.
- R3: In a block write, the slave acknowledges the address, the index N, the count X and each data byte. Data byte k (k from 0) is stored in register N+k.
- R4: In a block write, data bytes beyond the count X are not acknowledged and not stored.
- R5: The index pointer is 4 bits wide (only the low 4 bits of the index byte are used) and wraps from 15 to 0, for both writes and reads.
- R6: After an index-setting write phase, a repeated start and address 0xDD, the slave transmits register 8 first. It then transmits registers N, N+1, ... for as long as the host acknowledges, MSB first.
- R7: After the host answers a read byte with NACK, the slave keeps SDA released until the next start or stop.
- R8: A register output changes only when a data byte inside the count is accepted. A data byte cut short by a stop leaves every register unchanged.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: After reset, all 16 registers read zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| cfg_bytes | output | 128 | Register file; register i occupies bits [8i+7:8i] |

## Verification
Several rules are checked by assertions on every cycle:
- The SDA drive never changes while the synchronised SCL is high.
- A start always lands in the address state.
- A stop always lands in idle with SDA released.
- The register outputs move only while a write-data acknowledge is in progress.
- The index pointer only steps by one, except when a new index is loaded.

The directed scenarios are the only way to show the remaining behaviour:
- the exact acknowledge pattern, including NACKs after the count is used up and after a foreign address;
- the byte order of a read, with register 8 first;
- wrap-around at the end of the file;
- recovery from a stop or a repeated start in the middle of a byte.

// File: rtl/smbx_pkg.sv
`timescale 1ns/1ps
package smbx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } smbx_state_e;

    // bus events after synchronisation, all single-cycle except scl/sda levels
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } smbx_evt_t;

endpackage

// File: rtl/smbx_line_sync.sv
`timescale 1ns/1ps
module smbx_line_sync
    import smbx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_in,
    input  logic      sda_in,
    output smbx_evt_t evt
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[MSB];
            sda_d    <= sda_pipe[MSB];
        end
    end

    always_comb begin
        evt.scl      = scl_pipe[MSB];
        evt.sda      = sda_pipe[MSB];
        evt.scl_rise = scl_pipe[MSB] & ~scl_d;
        evt.scl_fall = ~scl_pipe[MSB] & scl_d;
        evt.start    = scl_pipe[MSB] & scl_d & sda_d & ~sda_pipe[MSB];
        evt.stop     = scl_pipe[MSB] & scl_d & ~sda_d & sda_pipe[MSB];
    end

endmodule

// File: rtl/smbx_regfile.sv
`timescale 1ns/1ps
module smbx_regfile #(
    parameter int NREG  = 16,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [7:0]        wdata,
    output logic [NREG*8-1:0] bytes_o
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [7:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= 8'h00;
            end else if (we && (waddr == IDX_W'(g))) begin
                q <= wdata;
            end
        end

        assign bytes_o[g*8 +: 8] = q;
    end

endmodule

// File: rtl/smb_idx_slave.sv
`timescale 1ns/1ps
module smb_idx_slave
    import smbx_pkg::*;
#(
    parameter logic [6:0] ADDR7       = 7'h6E,
    parameter int         NREG        = 16,
    parameter int         COUNT_IDX   = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic [NREG*8-1:0] cfg_bytes
);

    localparam int         IDX_W   = $clog2(NREG);
    localparam logic [7:0] WR_ADDR = {ADDR7, 1'b0};
    localparam logic [7:0] RD_ADDR = {ADDR7, 1'b1};
    localparam int         CNT_LSB = COUNT_IDX * 8;

    smbx_evt_t   evt;
    smbx_state_e state_q;
    smbx_state_e state_d;

    logic [3:0]       bitcnt_q;
    logic [7:0]       rx_q;
    logic [7:0]       tx_q;
    logic [IDX_W-1:0] ptr_q;
    logic [7:0]       left_q;
    logic             rd_mode_q;
    logic             host_ack_q;

    logic             byte_full;
    logic             counting;
    logic             reg_we;
    logic [7:0]       rd_byte;
    logic [7:0]       cnt_byte;

    smbx_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    smbx_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .waddr   (ptr_q),
        .wdata   (rx_q),
        .bytes_o (cfg_bytes)
    );

    assign byte_full = (bitcnt_q == 4'd8);
    assign counting  = (state_q == ST_ADDR)  || (state_q == ST_INDEX) ||
                       (state_q == ST_COUNT) || (state_q == ST_WDATA) ||
                       (state_q == ST_RDATA);
    assign rd_byte   = cfg_bytes[{ptr_q, 3'b000} +: 8];
    assign cnt_byte  = cfg_bytes[CNT_LSB +: 8];
    assign reg_we    = (state_q == ST_WDATA) && (state_d == ST_WDATA_ACK);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (evt.start) begin
            state_d = ST_ADDR;
        end else if (evt.stop) begin
            state_d = ST_IDLE;
        end else if (evt.scl_fall) begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_WAIT:      state_d = ST_WAIT;
                ST_ADDR: begin
                    if (byte_full) begin
                        state_d = ((rx_q == WR_ADDR) || (rx_q == RD_ADDR)) ? ST_ADDR_ACK : ST_WAIT;
                    end
                end
                ST_ADDR_ACK:  state_d = rd_mode_q ? ST_RDATA : ST_INDEX;
                ST_INDEX:     if (byte_full) state_d = ST_INDEX_ACK;
                ST_INDEX_ACK: state_d = ST_COUNT;
                ST_COUNT:     if (byte_full) state_d = ST_COUNT_ACK;
                ST_COUNT_ACK: state_d = ST_WDATA;
                ST_WDATA: begin
                    if (byte_full) begin
                        state_d = (left_q != 8'd0) ? ST_WDATA_ACK : ST_WAIT;
                    end
                end
                ST_WDATA_ACK: state_d = ST_WDATA;
                ST_RDATA:     if (byte_full) state_d = ST_RACK;
                ST_RACK:      state_d = host_ack_q ? ST_RDATA : ST_WAIT;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q   <= 4'd0;
            rx_q       <= 8'h00;
            tx_q       <= 8'hFF;
            ptr_q      <= '0;
            left_q     <= 8'd0;
            rd_mode_q  <= 1'b0;
            host_ack_q <= 1'b0;
        end else begin
            if (evt.start || evt.stop || (state_d != state_q)) begin
                bitcnt_q <= 4'd0;
            end else if (evt.scl_rise && counting && !byte_full) begin
                rx_q     <= {rx_q[6:0], evt.sda};
                bitcnt_q <= bitcnt_q + 4'd1;
            end

            if ((state_q == ST_RACK) && evt.scl_rise) begin
                host_ack_q <= ~evt.sda;
            end

            if ((state_q == ST_RDATA) && (state_d == ST_RDATA) && evt.scl_fall) begin
                tx_q <= {tx_q[6:0], 1'b1};
            end

            if ((state_q == ST_ADDR) && (state_d == ST_ADDR_ACK)) begin
                rd_mode_q <= rx_q[0];
            end

            if ((state_q == ST_ADDR_ACK) && (state_d == ST_RDATA)) begin
                tx_q <= cnt_byte;
            end

            if ((state_q == ST_INDEX) && (state_d == ST_INDEX_ACK)) begin
                ptr_q <= rx_q[IDX_W-1:0];
            end

            if ((state_q == ST_COUNT) && (state_d == ST_COUNT_ACK)) begin
                left_q <= rx_q;
            end

            if (reg_we) begin
                ptr_q  <= ptr_q + 1'b1;
                left_q <= left_q - 8'd1;
            end

            if ((state_q == ST_RACK) && (state_d == ST_RDATA)) begin
                tx_q  <= rd_byte;
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_INDEX_ACK, ST_COUNT_ACK, ST_WDATA_ACK: sda_pull = 1'b1;
            ST_RDATA: sda_pull = ~tx_q[7];
            default:  sda_pull = 1'b0;
        endcase
    end

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> (state_q == ST_ADDR)); // R2

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> ((state_q == ST_IDLE) && !sda_pull)); // R2

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !$past(evt.scl)); // R9

    AST_REG_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_bytes) |-> (state_q == ST_WDATA_ACK)); // R8

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) |->
            ((ptr_q == IDX_W'($past(ptr_q) + 1'b1)) || (state_q == ST_INDEX_ACK))); // R5

endmodule

// File: tb/smb_idx_slave_tb_top.sv
`timescale 1ns/1ps
module smb_idx_slave_tb_top;

    localparam int NREG = 16;
    localparam int Q    = 10;

    logic clk      = 1'b0;
    logic rst_n    = 1'b0;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic [NREG*8-1:0] cfg_bytes;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_regs [NREG];

    always #2.5 clk = ~clk;

    assign sda_line = host_sda & ~sda_pull;

    smb_idx_slave dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (host_scl),
        .sda_in    (sda_line),
        .sda_pull  (sda_pull),
        .cfg_bytes (cfg_bytes)
    );

    // R9 monitor: drive changes seen while SCL was high
    logic scl_at_pos = 1'b1;
    logic prev_pull  = 1'b0;
    int   drive_viol = 0;
    always @(posedge clk) scl_at_pos <= host_scl;
    always @(negedge clk) begin
        if (rst_n && (sda_pull !== prev_pull) && scl_at_pos) drive_viol++;
        prev_pull <= sda_pull;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < NREG; i++) chk(req, cfg_bytes[i*8 +: 8], exp_regs[i]);
    endtask

    task automatic bus_start;
        host_sda = 1'b1; waitq(Q);
        host_scl = 1'b1; waitq(Q);
        host_sda = 1'b0; waitq(Q);
        host_scl = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop;
        host_sda = 1'b0; waitq(Q);
        host_scl = 1'b1; waitq(Q);
        host_sda = 1'b1; waitq(Q);
    endtask

    task automatic send_bit(input logic b);
        host_sda = b;    waitq(Q);
        host_scl = 1'b1; waitq(Q);
        host_scl = 1'b0; waitq(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        host_sda = 1'b1; waitq(Q);
        host_scl = 1'b1; waitq(Q/2);
        ack = ~sda_line; waitq(Q/2);
        host_scl = 1'b0; waitq(Q);
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] d);
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            host_sda = 1'b1; waitq(Q);
            host_scl = 1'b1; waitq(Q/2);
            d = {d[6:0], sda_line}; waitq(Q/2);
            host_scl = 1'b0; waitq(Q);
        end
        send_bit(~give_ack);
    endtask

    task automatic block_write(input logic [7:0] idx, input logic [7:0] cnt,
                               input logic [7:0] dat [4], input int n);
        logic a;
        bus_start();
        wbyte(8'hDC, a); chk("R1 write address ack", a, 1'b1);
        wbyte(idx, a);   chk("R3 index ack", a, 1'b1);
        wbyte(cnt, a);   chk("R3 count ack", a, 1'b1);
        for (int k = 0; k < n; k++) begin
            wbyte(dat[k], a);
            if (k < int'(cnt)) begin
                chk("R3 data ack", a, 1'b1);
                exp_regs[(int'(idx) + k) % NREG] = dat[k];
            end else begin
                chk("R4 overrun nack", a, 1'b0);
            end
        end
        bus_stop();
    endtask

    task automatic block_read(input logic [7:0] idx, input int n);
        logic a;
        logic [7:0] d;
        bus_start();
        wbyte(8'hDC, a); chk("R6 index phase address ack", a, 1'b1);
        wbyte(idx, a);   chk("R6 index ack", a, 1'b1);
        bus_start();
        wbyte(8'hDD, a); chk("R1 read address ack", a, 1'b1);
        rbyte(1'b1, d);  chk("R6 count byte from register 8", d, exp_regs[8]);
        for (int k = 0; k < n; k++) begin
            rbyte(k < n - 1, d);
            chk("R6 read data byte", d, exp_regs[(int'(idx) + k) % NREG]);
        end
        waitq(Q);
        chk("R7 released after host nack", sda_pull, 1'b0);
        host_scl = 1'b1; waitq(Q/2);
        chk("R7 still released on extra clock", sda_line, 1'b1);
        waitq(Q/2);
        host_scl = 1'b0; waitq(Q);
        bus_stop();
    endtask

    task automatic t_reset;
        chk("R10 sda released after reset", sda_pull, 1'b0);
        chk_regs("R10 registers zero after reset");
    endtask

    task automatic t_write_basic;
        logic [7:0] d [4] = '{8'hA6, 8'hB7, 8'h03, 8'h00};
        block_write(8'd6, 8'd3, d, 3);
        chk_regs("R3 registers after block write");
    endtask

    task automatic t_write_overrun;
        logic [7:0] d [4] = '{8'h55, 8'h66, 8'h77, 8'h00};
        block_write(8'd10, 8'd1, d, 3);
        chk_regs("R4 extra bytes not stored");
    endtask

    task automatic t_write_wrap;
        logic [7:0] d [4] = '{8'h11, 8'h22, 8'h00, 8'h00};
        block_write(8'hFF, 8'd2, d, 2);
        chk_regs("R5 write wraps 15 to 0");
    endtask

    task automatic t_read_basic;
        block_read(8'd6, 3);
    endtask

    task automatic t_read_wrap;
        block_read(8'd15, 3);
        chk_regs("R5 read leaves registers unchanged");
    endtask

    task automatic t_bad_addr;
        logic a;
        bus_start();
        wbyte(8'hA0, a); chk("R1 foreign address nack", a, 1'b0);
        wbyte(8'h05, a); chk("R1 ignored byte nack", a, 1'b0);
        wbyte(8'h01, a); chk("R1 ignored byte nack", a, 1'b0);
        wbyte(8'hFF, a); chk("R1 ignored byte nack", a, 1'b0);
        bus_stop();
        chk_regs("R1 foreign traffic stores nothing");
    endtask

    task automatic t_abort;
        logic a;
        bus_start();
        wbyte(8'hDC, a); chk("R8 address ack", a, 1'b1);
        wbyte(8'd3, a);  chk("R8 index ack", a, 1'b1);
        wbyte(8'd2, a);  chk("R8 count ack", a, 1'b1);
        wbyte(8'h5A, a); chk("R8 first byte ack", a, 1'b1);
        exp_regs[3] = 8'h5A;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        chk_regs("R8 partial byte not stored");
        chk("R2 idle after stop", sda_pull, 1'b0);
        bus_start();
        wbyte(8'hDC, a); chk("R2 address ack", a, 1'b1);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        wbyte(8'hDC, a); chk("R2 restart address ack", a, 1'b1);
        wbyte(8'd12, a); chk("R2 index ack", a, 1'b1);
        wbyte(8'd1, a);  chk("R2 count ack", a, 1'b1);
        wbyte(8'h3C, a); chk("R2 data ack", a, 1'b1);
        exp_regs[12] = 8'h3C;
        bus_stop();
        chk_regs("R2 write after mid-byte restart");
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
        waitq(10);
        rst_n = 1'b1;
        waitq(10);
        t_reset();
        t_write_basic();
        t_write_overrun();
        t_write_wrap();
        t_read_basic();
        t_read_wrap();
        t_bad_addr();
        t_abort();
        chk("R9 drive changes only while SCL low", drive_viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule